// File: doc/BRIEF.md
# End-of-Discharge Voltage Monitor

This block watches a single cell as it runs down. Each conversion result arrives as an 8-bit code together with a one-cycle valid strobe. One code step is 2.4 V / 256. The block compares each code against a programmable threshold and raises two sticky flags. The warning flag trips below the threshold. The failure flag trips below a second level, set about 100 mV lower, which is the threshold minus 11 codes, floored at zero. While the load is in overload, no sample can set either flag. A flag drops only when a valid-charge strobe arrives while the stored voltage is back at or above that flag's level.

The flags also drive the display and the empty pin. During a warning, the segment-1 drive blinks: it toggles on every 4 Hz timebase tick. On a failure, every segment is blanked and the empty pin's driver is released so that the host can pull it high. A small register port lets software program the threshold and read back the threshold and the latest voltage sample.

Top module: `edv_monitor`

## Requirements
- R1: After reset the threshold register holds 70h and both flags are clear. With no flag set, segAllOff and emptyHiZ are 0 and seg1Out equals displayEn.
- R2: The threshold register is at address 0Ch. A write with regWrEn loads regWrData on the clock edge, and regRdData returns the threshold combinationally whenever regAddr is 0Ch. Addresses other than 0Bh and 0Ch read as 0.
- R3: The voltage register is at address 0Bh and is read-only. It loads sampleCode on each sampleValid edge, and writes to 0Bh leave it unchanged.
- R4: On a sampleValid edge with overload low and sampleCode strictly below the threshold, warnFlag is 1 from the next cycle. A code equal to the threshold does not set it.
- R5: On a sampleValid edge with overload low and sampleCode strictly below max(threshold − 11, 0), failFlag is 1 from the next cycle. When the threshold is below 11, failFlag can never set.
- R6: A sample taken while overload is high sets neither flag.
- R7: Once set, a flag stays set until chargeValid is seen with the stored voltage at or above that flag's own level: the threshold for warnFlag, the lowered level for failFlag. A chargeValid below that level leaves the flag set.
- R8: The flags are evaluated only on sampleValid. A threshold write alone never sets a flag.
- R9: While warnFlag is set and failFlag is clear, seg1Out is displayEn AND a blink phase. The phase is 0 when the warning begins and inverts on every tick4Hz cycle. While warnFlag is clear, seg1Out equals displayEn.
- R10: While failFlag is set, segAllOff and emptyHiZ are 1 and seg1Out is 0.
- R11: If a set condition and a clear condition hit the same flag in one cycle, the flag ends up set. Comparisons use the threshold held before any write in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register address for read and write |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Combinational read data |
| sampleValid | input | 1 | New voltage code is valid this cycle |
| sampleCode | input | 8 | Cell voltage code, 2.4 V / 256 per step |
| overload | input | 1 | Overload condition; blocks flag setting |
| chargeValid | input | 1 | Valid charge detected this cycle |
| displayEn | input | 1 | Display enabled |
| tick4Hz | input | 1 | One-cycle 4 Hz timebase pulse |
| warnFlag | output | 1 | Latched first end-of-discharge warning |
| failFlag | output | 1 | Latched final end-of-discharge flag |
| seg1Out | output | 1 | Segment-1 drive |
| segAllOff | output | 1 | Blank all segments |
| emptyHiZ | output | 1 | Release the empty pin to high impedance |

## Verification
The bench hits both comparators exactly at their boundaries: a code equal to the threshold, and a code equal to threshold − 11. An off-by-one design would raise a flag at equality, or leave it unraised one code below. It drives thresholds under 11, where a design that wraps the subtraction would trip the failure flag at almost every sample. It also lands a threshold write, a sample and a charge in the same cycle, which exposes a design that compares against the newly written value or lets the clear win. Finally it sends overload samples and low-voltage charge strobes, where a flag that was set or cleared wrongly would show at once on the outputs.

// File: rtl/edv_pkg.sv
package edv_pkg;
  typedef struct packed {
    logic loadThr;
    logic loadVolt;
    logic setWarn;
    logic setFail;
    logic clrWarn;
    logic clrFail;
  } ctlStrobes_t;

  typedef struct packed {
    logic sampleBelowWarn;
    logic sampleBelowFail;
    logic storedOkWarn;
    logic storedOkFail;
  } cmpResult_t;
endpackage

// File: rtl/edv_datapath.sv
module edv_datapath import edv_pkg::*; #(
  parameter int CODE_W = 8,
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] THR_ADDR = 4'hC,
  parameter logic [ADDR_W-1:0] VOLT_ADDR = 4'hB,
  parameter logic [CODE_W-1:0] THR_RESET = 8'h70,
  parameter int FAIL_OFFSET = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobe,
  input  logic [CODE_W-1:0] wrData,
  input  logic [CODE_W-1:0] sampleCode,
  input  logic [ADDR_W-1:0] rdAddr,
  output cmpResult_t        cmp,
  output logic [CODE_W-1:0] rdData,
  output logic [CODE_W-1:0] thrQ,
  output logic [CODE_W-1:0] voltQ
);
  localparam logic [CODE_W-1:0] OFFSET_CODE = CODE_W'(FAIL_OFFSET);

  logic [CODE_W-1:0] failThr;

  // Threshold register: software-writable
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              thrQ <= THR_RESET;
    else if (strobe.loadThr) thrQ <= wrData;
  end

  // Voltage register: refreshed from each valid sample
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                voltQ <= '0;
    else if (strobe.loadVolt) voltQ <= sampleCode;
  end

  // Lowered level for the failure flag, saturating at zero
  generate
    if (FAIL_OFFSET == 0) begin : gNoOffset
      assign failThr = thrQ;
    end else begin : gSatSub
      always_comb begin
        if (thrQ >= OFFSET_CODE) failThr = thrQ - OFFSET_CODE;
        else                     failThr = '0;
      end
    end
  endgenerate

  always_comb begin
    cmp.sampleBelowWarn = sampleCode < thrQ;
    cmp.sampleBelowFail = sampleCode < failThr;
    cmp.storedOkWarn    = voltQ >= thrQ;
    cmp.storedOkFail    = voltQ >= failThr;
  end

  always_comb begin
    if (rdAddr == THR_ADDR)       rdData = thrQ;
    else if (rdAddr == VOLT_ADDR) rdData = voltQ;
    else                          rdData = '0;
  end
endmodule

// File: rtl/edv_control.sv
module edv_control import edv_pkg::*; #(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] THR_ADDR = 4'hC
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              sampleValid,
  input  logic              overload,
  input  logic              chargeValid,
  input  logic              displayEn,
  input  logic              tick4Hz,
  input  cmpResult_t        cmp,
  output ctlStrobes_t       strobe,
  output logic              warnFlag,
  output logic              failFlag,
  output logic              seg1Out,
  output logic              segAllOff,
  output logic              emptyHiZ
);
  logic blinkPhase;
  logic sampleArmed;

  assign sampleArmed = sampleValid && !overload;

  always_comb begin
    strobe.loadThr  = regWrEn && (regAddr == THR_ADDR);
    strobe.loadVolt = sampleValid;
    strobe.setWarn  = sampleArmed && cmp.sampleBelowWarn;
    strobe.setFail  = sampleArmed && cmp.sampleBelowFail;
    strobe.clrWarn  = chargeValid && cmp.storedOkWarn;
    strobe.clrFail  = chargeValid && cmp.storedOkFail;
  end

  // Sticky flags; set wins over clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      warnFlag <= 1'b0;
      failFlag <= 1'b0;
    end else begin
      if (strobe.setWarn)      warnFlag <= 1'b1;
      else if (strobe.clrWarn) warnFlag <= 1'b0;
      if (strobe.setFail)      failFlag <= 1'b1;
      else if (strobe.clrFail) failFlag <= 1'b0;
    end
  end

  // Blink phase: held at 0 without warning, toggles on each 4 Hz tick
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          blinkPhase <= 1'b0;
    else if (!warnFlag) blinkPhase <= 1'b0;
    else if (tick4Hz)   blinkPhase <= ~blinkPhase;
  end

  always_comb begin
    segAllOff = failFlag;
    emptyHiZ  = failFlag;
    if (failFlag)      seg1Out = 1'b0;
    else if (warnFlag) seg1Out = displayEn && blinkPhase;
    else               seg1Out = displayEn;
  end
endmodule

// File: rtl/edv_monitor.sv
module edv_monitor import edv_pkg::*; #(
  parameter int CODE_W = 8,
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] THR_ADDR = 4'hC,
  parameter logic [ADDR_W-1:0] VOLT_ADDR = 4'hB,
  parameter logic [CODE_W-1:0] THR_RESET = 8'h70,
  parameter int FAIL_OFFSET = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [CODE_W-1:0] regWrData,
  output logic [CODE_W-1:0] regRdData,
  input  logic              sampleValid,
  input  logic [CODE_W-1:0] sampleCode,
  input  logic              overload,
  input  logic              chargeValid,
  input  logic              displayEn,
  input  logic              tick4Hz,
  output logic              warnFlag,
  output logic              failFlag,
  output logic              seg1Out,
  output logic              segAllOff,
  output logic              emptyHiZ
);
  ctlStrobes_t       strobe;
  cmpResult_t        cmp;
  logic [CODE_W-1:0] thrQ;
  logic [CODE_W-1:0] voltQ;

  edv_datapath #(
    .CODE_W(CODE_W), .ADDR_W(ADDR_W), .THR_ADDR(THR_ADDR),
    .VOLT_ADDR(VOLT_ADDR), .THR_RESET(THR_RESET), .FAIL_OFFSET(FAIL_OFFSET)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(regWrData),
    .sampleCode(sampleCode), .rdAddr(regAddr), .cmp(cmp),
    .rdData(regRdData), .thrQ(thrQ), .voltQ(voltQ)
  );

  edv_control #(.ADDR_W(ADDR_W), .THR_ADDR(THR_ADDR)) u_ctl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .sampleValid(sampleValid), .overload(overload), .chargeValid(chargeValid),
    .displayEn(displayEn), .tick4Hz(tick4Hz), .cmp(cmp), .strobe(strobe),
    .warnFlag(warnFlag), .failFlag(failFlag), .seg1Out(seg1Out),
    .segAllOff(segAllOff), .emptyHiZ(emptyHiZ)
  );
endmodule

// File: rtl/edv_monitor_chk.sv
module edv_monitor_chk #(
  parameter int CODE_W = 8,
  parameter int FAIL_OFFSET = 11
) (
  input logic              clk,
  input logic              rstN,
  input logic              sampleValid,
  input logic [CODE_W-1:0] sampleCode,
  input logic              overload,
  input logic              chargeValid,
  input logic              displayEn,
  input logic [CODE_W-1:0] thrQ,
  input logic              warnFlag,
  input logic              failFlag,
  input logic              seg1Out,
  input logic              segAllOff,
  input logic              emptyHiZ
);
  localparam int SUM_W = CODE_W + 1;

  assert_warn_sets_R4: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && !overload && (sampleCode < thrQ)) |=> warnFlag);

  assert_fail_sets_R5: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && !overload &&
     ((SUM_W'(sampleCode) + SUM_W'(FAIL_OFFSET)) < SUM_W'(thrQ))) |=> failFlag);

  assert_no_set_without_sample_R8: assert property (@(posedge clk) disable iff (!rstN)
    ((overload || !sampleValid) && !warnFlag) |=> !warnFlag);

  assert_overload_blocks_fail_R6: assert property (@(posedge clk) disable iff (!rstN)
    ((overload || !sampleValid) && !failFlag) |=> !failFlag);

  assert_latched_R7: assert property (@(posedge clk) disable iff (!rstN)
    (warnFlag && !chargeValid) |=> warnFlag);

  assert_fail_outputs_R10: assert property (@(posedge clk) disable iff (!rstN)
    failFlag |-> (segAllOff && emptyHiZ && !seg1Out));

  assert_seg1_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    !warnFlag && !failFlag |-> (seg1Out == displayEn));
endmodule

bind edv_monitor edv_monitor_chk #(.CODE_W(CODE_W), .FAIL_OFFSET(FAIL_OFFSET)) u_chk (
  .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleCode(sampleCode),
  .overload(overload), .chargeValid(chargeValid), .displayEn(displayEn),
  .thrQ(thrQ), .warnFlag(warnFlag), .failFlag(failFlag), .seg1Out(seg1Out),
  .segAllOff(segAllOff), .emptyHiZ(emptyHiZ)
);

// File: tb/sim_edv_monitor.sv
`timescale 1ns/1ps
module sim_edv_monitor;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [3:0] regAddr = 4'h0;
  logic [7:0] regWrData = 8'h0;
  logic [7:0] regRdData;
  logic       sampleValid = 1'b0;
  logic [7:0] sampleCode = 8'h0;
  logic       overload = 1'b0;
  logic       chargeValid = 1'b0;
  logic       displayEn = 1'b1;
  logic       tick4Hz = 1'b0;
  logic       warnFlag, failFlag, seg1Out, segAllOff, emptyHiZ;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  // reference state
  logic [7:0] thrM, voltM;
  logic       warnM, failM, phaseM;

  always #2.5 clk = ~clk;

  edv_monitor u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .sampleValid(sampleValid),
    .sampleCode(sampleCode), .overload(overload), .chargeValid(chargeValid),
    .displayEn(displayEn), .tick4Hz(tick4Hz), .warnFlag(warnFlag),
    .failFlag(failFlag), .seg1Out(seg1Out), .segAllOff(segAllOff),
    .emptyHiZ(emptyHiZ)
  );

  function automatic logic [7:0] lowLevel(input logic [7:0] t);
    return (t >= 8'd11) ? t - 8'd11 : 8'd0;
  endfunction

  function automatic logic expSeg1();
    if (failM) return 1'b0;
    if (warnM) return displayEn & phaseM;
    return displayEn;
  endfunction

  function automatic logic [7:0] expRead(input logic [3:0] a);
    if (a == 4'hC) return thrM;
    if (a == 4'hB) return voltM;
    return 8'h00;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic checkOutputs();
    check("R4 warnFlag", warnFlag, warnM);
    check("R5 failFlag", failFlag, failM);
    check("R9 seg1Out", seg1Out, expSeg1());
    check("R10 segAllOff", segAllOff, failM);
    check("R10 emptyHiZ", emptyHiZ, failM);
  endtask

  // One clock: inputs already driven; advance model at the edge, compare at negedge
  task automatic step();
    logic setW, setF, clrW, clrF;
    @(posedge clk);
    setW = sampleValid && !overload && (sampleCode < thrM);
    setF = sampleValid && !overload && (sampleCode < lowLevel(thrM));
    clrW = chargeValid && (voltM >= thrM);
    clrF = chargeValid && (voltM >= lowLevel(thrM));
    phaseM = !warnM ? 1'b0 : (tick4Hz ? ~phaseM : phaseM);
    if (regWrEn && regAddr == 4'hC) thrM = regWrData;
    if (sampleValid) voltM = sampleCode;
    warnM = setW ? 1'b1 : (clrW ? 1'b0 : warnM);
    failM = setF ? 1'b1 : (clrF ? 1'b0 : failM);
    @(negedge clk);
    checkOutputs();
  endtask

  task automatic idle();
    regWrEn = 0; sampleValid = 0; chargeValid = 0; tick4Hz = 0; overload = 0;
  endtask

  task automatic writeThr(input logic [7:0] v);
    regWrEn = 1; regAddr = 4'hC; regWrData = v; step(); idle();
  endtask

  task automatic sample(input logic [7:0] c, input logic ov);
    sampleValid = 1; sampleCode = c; overload = ov; step(); idle();
  endtask

  task automatic charge();
    chargeValid = 1; step(); idle();
  endtask

  task automatic readCheck(input string tag, input logic [3:0] a);
    regAddr = a; #0.5;
    check(tag, regRdData, expRead(a));
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    thrM = 8'h70; voltM = 8'h00; warnM = 0; failM = 0; phaseM = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 warnFlag", warnFlag, 0);
    check("R1 failFlag", failFlag, 0);
    check("R1 segAllOff", segAllOff, 0);
    check("R1 emptyHiZ", emptyHiZ, 0);
    check("R1 seg1Out", seg1Out, 1);
    readCheck("R1 threshold reset", 4'hC);
    check("R1 threshold value", regRdData, 8'h70);

    // R2 read/write threshold, unmapped reads zero
    writeThr(8'h80);
    readCheck("R2 threshold readback", 4'hC);
    check("R2 threshold value", regRdData, 8'h80);
    readCheck("R2 unmapped", 4'h3);
    writeThr(8'h70);

    // R3 voltage register loads on sample, ignores writes
    sample(8'h90, 0);
    readCheck("R3 voltage load", 4'hB);
    regWrEn = 1; regAddr = 4'hB; regWrData = 8'h11; step(); idle();
    readCheck("R3 voltage write ignored", 4'hB);
    check("R3 voltage value", regRdData, 8'h90);

    // R4 boundary: equal does not set, one below does
    sample(8'h70, 0);
    check("R4 equal no set", warnFlag, 0);
    // R6 overload blocks
    sample(8'h10, 1);
    check("R6 overload warn", warnFlag, 0);
    check("R6 overload fail", failFlag, 0);
    sample(8'h6F, 0);
    check("R4 below sets", warnFlag, 1);
    check("R5 not yet fail", failFlag, 0);
    // R9 blink: phase 0 then toggles per tick
    check("R9 phase start", seg1Out, 0);
    tick4Hz = 1; step(); idle();
    check("R9 toggled on", seg1Out, 1);
    step();
    check("R9 held", seg1Out, 1);
    tick4Hz = 1; step(); idle();
    check("R9 toggled off", seg1Out, 0);

    // R5 boundary at 70h-11 = 65h
    sample(8'h65, 0);
    check("R5 equal no fail", failFlag, 0);
    sample(8'h64, 0);
    check("R5 below fails", failFlag, 1);
    check("R10 blank", segAllOff, 1);
    check("R10 empty released", emptyHiZ, 1);

    // R7 charge with low voltage keeps flags
    charge();
    check("R7 warn held", warnFlag, 1);
    check("R7 fail held", failFlag, 1);
    // stored voltage between levels: clears fail only
    sample(8'h68, 0);
    charge();
    check("R7 fail cleared", failFlag, 0);
    check("R7 warn kept", warnFlag, 1);
    sample(8'h70, 0);
    charge();
    check("R7 warn cleared", warnFlag, 0);

    // R8 threshold write alone does not set
    writeThr(8'hF0);
    step();
    check("R8 write no set", warnFlag, 0);

    // R11 set beats clear, old threshold used for compare
    writeThr(8'h70);
    sample(8'hA0, 0);
    regWrEn = 1; regAddr = 4'hC; regWrData = 8'h20;
    sampleValid = 1; sampleCode = 8'h6F; chargeValid = 1;
    step(); idle();
    check("R11 set wins", warnFlag, 1);
    readCheck("R11 new threshold", 4'hC);
    charge();

    // R5 low threshold: never fails
    writeThr(8'h05);
    sample(8'h00, 0);
    check("R5 floor no fail", failFlag, 0);
    check("R4 low thr warn", warnFlag, 1);
    sample(8'hFF, 0);
    charge();

    // Constrained random
    writeThr(8'h70);
    for (int i = 0; i < 4000; i++) begin
      regWrEn     = ($urandom_range(0, 39) == 0);
      regAddr     = 4'($urandom_range(10, 13));
      regWrData   = 8'($urandom_range(8'h00, 8'h90));
      sampleValid = ($urandom_range(0, 3) == 0);
      sampleCode  = 8'($urandom_range(0, 3) == 0 ? $urandom_range(0, 255)
                                                 : $urandom_range(int'(thrM) - 16 < 0 ? 0 : int'(thrM) - 16,
                                                                  int'(thrM) + 4 > 255 ? 255 : int'(thrM) + 4));
      overload    = ($urandom_range(0, 7) == 0);
      chargeValid = ($urandom_range(0, 9) == 0);
      tick4Hz     = ($urandom_range(0, 2) == 0);
      displayEn   = ($urandom_range(0, 7) != 0);
      #0.5;
      check("R2 R3 readback", regRdData, expRead(regAddr));
      step();
    end
    idle();

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule